// File: doc/BRIEF.md
# Two-Lane DCT Coefficient Watermark Marker

This block hides four watermark bits inside each 8x8 block of luminance DCT coefficients. Coefficients arrive two at a time in row-major order: lane 0 carries the even index and lane 1 the odd index. A block therefore takes 32 beats. A 4-bit watermark word comes with the first beat of each block. The DC term and the three lowest AC terms (row 0 column 1, row 1 column 0, row 1 column 1) are each multiplied by a gain slightly above or below unity. The watermark bit for that coefficient picks the direction. Every other coefficient leaves the block unchanged.

Because of the two lanes, a block's marking is done in two beats. Beat 0 carries indices 0 and 1, and beat 4 carries indices 8 and 9. A small beat tracker follows the position inside the block through four named states:
- `BS_DC_PAIR`: beat 0.
- `BS_SKIP_TOP`: beats 1 to 3.
- `BS_AC_PAIR`: beat 4.
- `BS_PASS_REST`: beats 5 to 31.

The transitions are:
- DC_PAIR→SKIP_TOP on an accepted beat.
- SKIP_TOP→AC_PAIR on the accepted beat 3.
- AC_PAIR→PASS_REST on an accepted beat.
- PASS_REST→DC_PAIR on the accepted beat 31.

Each accepted beat passes through a single output register. A valid/ready handshake on both sides supports backpressure.

Top module: `wm_dct_marker`

## Requirements
- R1: A coefficient at row-major index i arrives on lane i%2 during beat i/2. Every coefficient whose index is not 0, 1, 8 or 9 leaves on the same lane of the matching output beat with its value unchanged.
- R2: A marked coefficient c is multiplied by the gain G = 32768+alpha when its bit is 1, or G = 32768-alpha when its bit is 0. The result is (c*G + 16384) shifted right arithmetically by 15.
- R3: alpha is 655 (Q1.15) for index 0 and 3277 for indices 1, 8 and 9.
- R4: in_wm is taken only on beat 0 of a block. Bit 3 marks index 0, bit 2 marks index 1, bit 1 marks index 8 and bit 0 marks index 9. Values on in_wm during beats 1 to 31 have no effect.
- R5: A marked result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R6: out_last is 1 on the 32nd output beat of every block and 0 on every other output beat.
- R7: in_ready equals (!out_valid || out_ready). A beat accepted at a clock edge appears on the outputs right after that edge. While out_valid is 1 and out_ready is 0, the outputs hold.
- R8: After reset, out_valid is 0, in_ready is 1, and the next accepted beat is treated as beat 0 of a block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_c0 | input | 16 | Even-index coefficient, signed |
| in_c1 | input | 16 | Odd-index coefficient, signed |
| in_wm | input | 4 | Watermark word, sampled on beat 0 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream can take a beat |
| out_c0 | output | 16 | Even-index result, signed |
| out_c1 | output | 16 | Odd-index result, signed |
| out_last | output | 1 | Final beat of a block |

## Verification
The hardest case to reach is beat 4 of a block. There, the two AC marks must use bits captured 4 or more beats earlier, while in_wm shows unrelated values and the handshake on either side may have stalled for any number of cycles in between. The stimulus holds the offered beat across random input gaps and randomises in_wm on every non-first beat. It also runs long downstream stalls, so the captured word has to survive both. Dedicated blocks drive the marked positions to full-scale positive and negative values with all bits set, to reach both saturation limits. Another block uses small odd values with all bits clear, to test rounding of negative products.

// File: rtl/wm_pkg.sv
package wm_pkg;
    typedef enum logic [1:0] {
        BS_DC_PAIR   = 2'd0,
        BS_SKIP_TOP  = 2'd1,
        BS_AC_PAIR   = 2'd2,
        BS_PASS_REST = 2'd3
    } beat_state_t;
endpackage

// File: rtl/wm_beat_tracker.sv
module wm_beat_tracker
    import wm_pkg::*;
#(
    parameter int BLK_DIM = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        beat_fire,
    output beat_state_t                                 state_o,
    output logic [$clog2(BLK_DIM*BLK_DIM/2)-1:0]        cnt_o,
    output logic                                        last_beat_o
);
    localparam int BEATS    = BLK_DIM * BLK_DIM / 2;
    localparam int ROW1     = BLK_DIM / 2;
    localparam int CNT_W    = $clog2(BEATS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BEATS - 1);
    localparam logic [CNT_W-1:0] CNT_GAP_END = CNT_W'(ROW1 - 1);

    beat_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    assign last_beat_o = (cnt_q == CNT_LAST);
    assign state_o     = state_q;
    assign cnt_o       = cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_DC_PAIR:   if (beat_fire) state_d = (ROW1 > 1) ? BS_SKIP_TOP : BS_AC_PAIR;
            BS_SKIP_TOP:  if (beat_fire && cnt_q == CNT_GAP_END) state_d = BS_AC_PAIR;
            BS_AC_PAIR:   if (beat_fire) state_d = BS_PASS_REST;
            BS_PASS_REST: if (beat_fire && cnt_q == CNT_LAST) state_d = BS_DC_PAIR;
            default:      state_d = BS_DC_PAIR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BS_DC_PAIR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (beat_fire) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R8
    head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_DC_PAIR) |-> (cnt_q == '0));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && last_beat_o) |=> (state_q == BS_DC_PAIR && cnt_q == '0));
endmodule

// File: rtl/wm_mark_lane.sv
module wm_mark_lane #(
    parameter int COEF_W = 16,
    parameter int FRAC   = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [COEF_W-1:0] coef_i,
    input  logic                     mark_i,
    input  logic                     bit_i,
    input  logic [FRAC-1:0]          alpha_i,
    output logic signed [COEF_W-1:0] res_o
);
    localparam int GW = FRAC + 2;
    localparam int PW = COEF_W + GW;
    localparam logic signed [GW-1:0] GAIN_ONE = {2'b01, {FRAC{1'b0}}};
    localparam logic signed [PW-1:0] HALF_LSB = PW'(1) << (FRAC - 1);
    localparam logic signed [PW-1:0] SAT_MAX  = (PW'(1) << (COEF_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] SAT_MIN  = -(PW'(1) << (COEF_W - 1));

    logic signed [GW-1:0] alpha_s, gain_up, gain_dn, gain;
    logic signed [PW-1:0] prod, rounded, scaled;
    logic signed [COEF_W-1:0] clipped;

    always_comb begin
        alpha_s = $signed({2'b00, alpha_i});
        gain_up = GAIN_ONE + alpha_s;
        gain_dn = GAIN_ONE - alpha_s;
        gain    = bit_i ? gain_up : gain_dn;
        prod    = coef_i * gain;
        rounded = prod + HALF_LSB;
        scaled  = rounded >>> FRAC;
        if (scaled > SAT_MAX)      clipped = SAT_MAX[COEF_W-1:0];
        else if (scaled < SAT_MIN) clipped = SAT_MIN[COEF_W-1:0];
        else                       clipped = scaled[COEF_W-1:0];
        res_o = mark_i ? clipped : coef_i;
    end

    // R2
    up_no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_i && bit_i && coef_i >= 0) |-> (res_o >= coef_i));

    // R2
    down_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_i && !bit_i && coef_i >= 0) |-> (res_o <= coef_i && res_o >= 0));
endmodule

// File: rtl/wm_dct_marker.sv
module wm_dct_marker
    import wm_pkg::*;
#(
    parameter int COEF_W   = 16,
    parameter int BLK_DIM  = 8,
    parameter int FRAC     = 15,
    parameter int ALPHA_DC = 655,
    parameter int ALPHA_AC = 3277
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [COEF_W-1:0] in_c0,
    input  logic signed [COEF_W-1:0] in_c1,
    input  logic [3:0]               in_wm,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [COEF_W-1:0] out_c0,
    output logic signed [COEF_W-1:0] out_c1,
    output logic                     out_last
);
    localparam int CNT_W = $clog2(BLK_DIM * BLK_DIM / 2);
    localparam logic [FRAC-1:0] A_DC = FRAC'(ALPHA_DC);
    localparam logic [FRAC-1:0] A_AC = FRAC'(ALPHA_AC);

    beat_state_t          state;
    logic [CNT_W-1:0]     beat_cnt;
    logic                 last_beat, in_fire;
    logic [3:0]           wm_hold, wm_now;
    logic                 mark, bit0, bit1;
    logic [FRAC-1:0]      alpha0;
    logic signed [COEF_W-1:0] res0, res1;

    assign in_ready = !out_valid || out_ready;
    assign in_fire  = in_valid && in_ready;

    wm_beat_tracker #(.BLK_DIM(BLK_DIM)) u_track (
        .clk(clk), .rst_n(rst_n), .beat_fire(in_fire),
        .state_o(state), .cnt_o(beat_cnt), .last_beat_o(last_beat)
    );

    always_comb begin
        wm_now = (state == BS_DC_PAIR) ? in_wm : wm_hold;
        mark   = 1'b0;
        bit0   = 1'b0;
        bit1   = 1'b0;
        alpha0 = A_AC;
        unique case (state)
            BS_DC_PAIR: begin
                mark = 1'b1; bit0 = wm_now[3]; bit1 = wm_now[2]; alpha0 = A_DC;
            end
            BS_AC_PAIR: begin
                mark = 1'b1; bit0 = wm_now[1]; bit1 = wm_now[0]; alpha0 = A_AC;
            end
            BS_SKIP_TOP, BS_PASS_REST: mark = 1'b0;
            default: mark = 1'b0;
        endcase
    end

    wm_mark_lane #(.COEF_W(COEF_W), .FRAC(FRAC)) u_lane0 (
        .clk(clk), .rst_n(rst_n), .coef_i(in_c0), .mark_i(mark),
        .bit_i(bit0), .alpha_i(alpha0), .res_o(res0)
    );

    wm_mark_lane #(.COEF_W(COEF_W), .FRAC(FRAC)) u_lane1 (
        .clk(clk), .rst_n(rst_n), .coef_i(in_c1), .mark_i(mark),
        .bit_i(bit1), .alpha_i(A_AC), .res_o(res1)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_c0    <= '0;
            out_c1    <= '0;
            out_last  <= 1'b0;
            wm_hold   <= '0;
        end else begin
            if (in_ready) out_valid <= in_valid;
            if (in_fire) begin
                out_c0   <= res0;
                out_c1   <= res1;
                out_last <= last_beat;
                if (state == BS_DC_PAIR) wm_hold <= in_wm;
            end
        end
    end

    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_c0) &&
                                       $stable(out_c1) && $stable(out_last)));

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && state == BS_SKIP_TOP) |=>
            (out_c0 == $past(in_c0) && out_c1 == $past(in_c1)));
endmodule

// File: tb/wm_dct_marker_bench.sv
module wm_dct_marker_bench;
    localparam int BEATS = 32;
    localparam int NBLK  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic signed [15:0] in_c0 = '0, in_c1 = '0;
    logic [3:0] in_wm = '0;
    logic in_ready, out_valid, out_last;
    logic signed [15:0] out_c0, out_c1;

    int tests = 0, fails = 0;
    bit done = 0;

    int    e0_q[$], e1_q[$];
    bit    el_q[$];
    string t0_q[$], t1_q[$];

    always #4 clk = ~clk;

    wm_dct_marker u_wm_dct_marker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_c0(in_c0), .in_c1(in_c1), .in_wm(in_wm), .out_valid(out_valid),
        .out_ready(out_ready), .out_c0(out_c0), .out_c1(out_c1), .out_last(out_last)
    );

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_marked(int idx);
        return idx == 0 || idx == 1 || idx == 8 || idx == 9;
    endfunction

    function automatic int bit_pos(int idx);
        case (idx)
            0: return 3;
            1: return 2;
            8: return 1;
            default: return 0;
        endcase
    endfunction

    // R2 R3 R5 reference arithmetic
    function automatic int ref_scale(int c, bit b, bit dc, output bit sat);
        longint alpha, g, r;
        alpha = dc ? 655 : 3277;
        g = b ? 32768 + alpha : 32768 - alpha;
        r = (longint'(c) * g + 16384) >>> 15;
        sat = 1'b0;
        if (r > 32767)  begin r = 32767;  sat = 1'b1; end
        if (r < -32768) begin r = -32768; sat = 1'b1; end
        return int'(r);
    endfunction

    function automatic int gen_coef(int b, int idx);
        if (b == 2) return is_marked(idx) ? 32767 : idx;
        if (b == 3) return is_marked(idx) ? -32768 : -idx;
        if (b == 4) begin
            case (idx)
                0: return -5;
                1: return 7;
                8: return -32768;
                9: return 32767;
                default: return idx * 100;
            endcase
        end
        return int'($signed(16'($urandom)));
    endfunction

    function automatic logic [3:0] gen_wm(int b);
        if (b == 2 || b == 3) return 4'hF;
        if (b == 4) return 4'h0;
        return 4'(b * 7 + 3);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int blk = 0, beat = 0;
        bit pending = 0;
        logic [3:0] wm_cap = '0;
        repeat (3) @(posedge clk);
        #2;
        // R8
        check(out_valid == 1'b0, "R8", out_valid, 0);
        check(in_ready == 1'b1, "R8", in_ready, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        while ((blk < NBLK || e0_q.size() > 0) && !done) begin
            @(posedge clk); #1;
            if (!pending && blk < NBLK && ($urandom % 4 != 0)) begin
                in_c0 = 16'(gen_coef(blk, 2 * beat));
                in_c1 = 16'(gen_coef(blk, 2 * beat + 1));
                in_wm = (beat == 0) ? gen_wm(blk) : 4'($urandom);
                in_valid = 1'b1;
                pending = 1;
            end else if (pending && beat != 0) begin
                in_wm = 4'($urandom);
            end else if (!pending) begin
                in_valid = 1'b0;
                in_wm = 4'($urandom);
            end
            if (blk >= 6 && blk <= 7) out_ready = ($urandom % 8 == 0);
            else                      out_ready = ($urandom % 4 != 0);
            #3;
            // R7
            check(out_valid == (e0_q.size() > 0), "R7", out_valid, e0_q.size() > 0);
            check(in_ready == (!out_valid || out_ready), "R7", in_ready, !out_valid || out_ready);
            if (out_valid && out_ready && e0_q.size() > 0) begin
                int x0, x1; bit xl; string g0, g1;
                x0 = e0_q.pop_front(); x1 = e1_q.pop_front(); xl = el_q.pop_front();
                g0 = t0_q.pop_front(); g1 = t1_q.pop_front();
                check(int'(out_c0) == x0, g0, int'(out_c0), x0);
                check(int'(out_c1) == x1, g1, int'(out_c1), x1);
                // R6
                check(out_last == xl, "R6", out_last, xl);
            end
            if (in_valid && in_ready) begin
                int r0, r1, i0, i1; bit s0, s1;
                logic [3:0] w;
                if (beat == 0) wm_cap = in_wm;
                w = wm_cap;
                i0 = 2 * beat; i1 = i0 + 1;
                r0 = int'(in_c0); r1 = int'(in_c1);
                s0 = 0; s1 = 0;
                if (is_marked(i0)) r0 = ref_scale(r0, w[bit_pos(i0)], i0 == 0, s0);
                if (is_marked(i1)) r1 = ref_scale(r1, w[bit_pos(i1)], 1'b0, s1);
                e0_q.push_back(r0);
                e1_q.push_back(r1);
                el_q.push_back(beat == BEATS - 1);
                t0_q.push_back(is_marked(i0) ? (s0 ? "R5" : "R2/R3/R4") : "R1");
                t1_q.push_back(is_marked(i1) ? (s1 ? "R5" : "R2/R3/R4") : "R1");
                pending = 0;
                beat++;
                if (beat == BEATS) begin beat = 0; blk++; end
            end
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule